// File: doc/BRIEF.md
# Host Mailbox FIFO Interface

This block connects a host processor to a byte-wide service controller. Each direction has its own queue. The host reaches the block through a single-cycle 32-bit register port, which gives it three registers:

- a condition/enable register that holds interrupt requests and their enables,
- a data window that pushes outgoing bytes and pops incoming ones,
- a status register whose sticky overflow latch is cleared by writing a one.

The controller side is two byte streams with valid/ready handshakes. Outgoing bytes leave on the transmit stream in the order the host wrote them. Incoming bytes are always accepted from the receive stream. A byte that arrives while the receive queue is full is dropped and recorded as an overflow.

A single level-sensitive interrupt output is raised when any enabled condition is active. A typical driver follows this sequence:

1. Enable the receive-not-empty source.
2. Write a command byte, then any parameter bytes.
3. Wait for the interrupt.
4. Read the reply bytes from the data window until the receive-not-empty condition drops.

Top module: `mbox_host_link`

## Requirements
- R1: After reset both queues are empty, all enables are 0, `irq` is low, the status register reads 0x3 and the condition/enable register reads 0x3.
- R2: Registers are selected by bits 3:2 of the byte address: 0x0 is condition/enable, 0x4 is data and 0x8 is status. Byte offset 0xC reads zero, and writes to it change nothing.
- R3: A write to offset 0x4 queues `reg_wdata[15:8]` for transmit. Queued bytes appear on `tx_data` with `tx_valid` high, in write order, and each one stays stable until a cycle in which `tx_ready` is high.
- R4: A data write while the transmit queue holds DEPTH bytes is discarded. A full queue remains full until a byte leaves on the transmit stream.
- R5: The receive stream has `rx_ready` always high, and a byte with `rx_valid` high is stored when the queue is not full. A read of offset 0x4 returns the oldest stored byte in bits 15:8, with every other bit zero, and removes it.
- R6: A read of offset 0x4 while the receive queue is empty returns zero and leaves the queue unchanged. The next byte that arrives is the next byte read.
- R7: A byte presented with `rx_valid` while the receive queue is full is dropped, even if the host reads in the same cycle, and the overflow latch is set. Setting the latch takes priority over a clear in the same cycle.
- R8: Writing a 1 to status bit 3 clears the overflow latch. Writing zeros, or ones to status bits 0 to 2, changes neither the latch nor either queue.
- R9: Status bits 0, 1, 2 and 3 are transmit-empty, transmit-not-full, receive-not-empty and overflow. Bits 3:0 of the condition/enable register read back the same four conditions and ignore writes. All other status bits read zero.
- R10: Bits 7:4 of the condition/enable register are writable enables for conditions 0 to 3, and a 1 enables the condition. `irq` is high exactly when some condition is active while its enable is 1.
- R11: Transmit-not-full reads 0 from the cycle after the DEPTH-th accepted write. It returns to 1 from the cycle after a byte leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe; a data read pops a byte |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| tx_data | output | 8 | Oldest queued transmit byte (zero when empty) |
| tx_valid | output | 1 | Transmit queue holds at least one byte |
| tx_ready | input | 1 | Controller takes the byte in this cycle |
| rx_data | input | 8 | Byte from the controller |
| rx_valid | input | 1 | `rx_data` carries a byte in this cycle |
| rx_ready | output | 1 | Always 1; overflow is reported rather than stalled |
| irq | output | 1 | Level interrupt, OR of enabled active conditions |

## Verification
The assertions check several properties on every cycle:

- A held transmit byte stays stable while the controller stalls.
- A full transmit queue stays full until a byte leaves.
- The overflow latch rises only after a byte arrived at a full receive queue, and it stays set until a clearing write.
- A dropped byte leaves the receive queue full.
- An empty-queue data read returns zero.
- `irq` stays low while all enables are 0.

The scoreboard scenarios cover the behaviour that needs sequences of accesses:

- the ordering of bytes through both queues,
- discarding of the write that follows the DEPTH-th one,
- the exact status and interrupt values at each fill level,
- that write-one-to-clear touches only the overflow latch,
- that an empty read does not skew the receive pointers.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int BYTE_W   = 8;
  localparam int REG_W    = 32;
  localparam int LANE_LSB = 8;
  localparam int NCOND    = 4;

  // condition bit positions, shared by status and condition/enable
  localparam int C_TXE  = 0;
  localparam int C_TXNF = 1;
  localparam int C_RXNE = 2;
  localparam int C_RXO  = 3;

  // word indices (byte address bits 3:2)
  localparam int W_INTR = 0;
  localparam int W_DATA = 1;
  localparam int W_STAT = 2;

  typedef logic [NCOND-1:0] cond_t;

  function automatic logic [REG_W-1:0] lane_pack(input logic [BYTE_W-1:0] b);
    logic [REG_W-1:0] w;
    w = '0;
    w[LANE_LSB +: BYTE_W] = b;
    return w;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_take(input logic [REG_W-1:0] w);
    return w[LANE_LSB +: BYTE_W];
  endfunction

  function automatic logic [REG_W-1:0] intr_word(input cond_t req, input cond_t en);
    logic [REG_W-1:0] w;
    w = '0;
    w[NCOND-1:0]       = req;
    w[2*NCOND-1:NCOND] = en;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] stat_word(input cond_t req);
    logic [REG_W-1:0] w;
    w = '0;
    w[NCOND-1:0] = req;
    return w;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  output logic         irq
);

  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = req[i] & en[i];
  end

  assign irq = |gated;

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic              rx_drop,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_pop,
  output logic              rd_empty_hit,
  output logic              ovf_clr,
  output logic              ovf_flag,
  output cond_t             cond,
  output cond_t             mask_q
);

  localparam int WW = ADDR_W - 2;

  logic [WW-1:0] word;
  logic          sel_intr, sel_data, sel_stat;
  logic          unused_bits;

  assign word     = reg_addr[ADDR_W-1:2];
  assign sel_intr = (word == WW'(W_INTR));
  assign sel_data = (word == WW'(W_DATA));
  assign sel_stat = (word == WW'(W_STAT));

  assign unused_bits = ^{reg_addr[1:0], reg_wdata[REG_W-1:LANE_LSB+BYTE_W], reg_wdata[C_RXO-1:0]};

  assign tx_push      = reg_wr && sel_data && !tx_full;
  assign tx_byte      = lane_take(reg_wdata);
  assign rx_pop       = reg_rd && sel_data && !rx_empty;
  assign rd_empty_hit = reg_rd && sel_data && rx_empty;
  assign ovf_clr      = reg_wr && sel_stat && reg_wdata[C_RXO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (reg_wr && sel_intr) mask_q <= reg_wdata[2*NCOND-1:NCOND];
      ovf_flag <= rx_drop | (ovf_flag & ~ovf_clr);
    end
  end

  always_comb begin
    cond         = '0;
    cond[C_TXE]  = tx_empty;
    cond[C_TXNF] = ~tx_full;
    cond[C_RXNE] = ~rx_empty;
    cond[C_RXO]  = ovf_flag;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_intr)      reg_rdata = intr_word(cond, mask_q);
      else if (sel_data) reg_rdata = lane_pack(rx_head);
      else if (sel_stat) reg_rdata = stat_word(cond);
    end
  end

endmodule

// File: rtl/mbox_host_link.sv
module mbox_host_link
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);

  logic              tx_push, tx_pop, tx_empty, tx_full;
  logic [BYTE_W-1:0] tx_byte;
  logic              rx_push, rx_pop, rx_empty, rx_full, rx_drop;
  logic [BYTE_W-1:0] rx_head;
  logic              rd_empty_hit, ovf_clr, ovf_flag;
  cond_t             cond, mask_q;

  assign rx_ready = 1'b1;
  assign rx_push  = rx_valid && !rx_full;
  assign rx_drop  = rx_valid && rx_full;
  assign tx_valid = !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;

  mbox_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata(tx_byte), .pop(tx_pop),
    .head(tx_data), .empty(tx_empty), .full(tx_full)
  );

  mbox_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_data), .pop(rx_pop),
    .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  mbox_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_empty(rx_empty), .rx_head(rx_head), .rx_drop(rx_drop),
    .tx_push(tx_push), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .rd_empty_hit(rd_empty_hit), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
    .cond(cond), .mask_q(mask_q)
  );

  mbox_irq #(.N(NCOND)) u_irq (
    .req(cond), .en(mask_q), .irq(irq)
  );

endmodule

// File: rtl/mbox_host_link_chk.sv
module mbox_host_link_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_full,
  input logic        rx_valid,
  input logic        rx_full,
  input logic        rx_drop,
  input logic        rx_pop,
  input logic        ovf_flag,
  input logic        ovf_clr,
  input logic        rd_empty_hit,
  input logic [31:0] reg_rdata,
  input logic [3:0]  mask_q,
  input logic        irq
);

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4
  tx_full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !(tx_valid && tx_ready)) |=> tx_full);

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(rx_valid && rx_full));

  // R7
  drop_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_pop) |=> rx_full);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty_hit |-> (reg_rdata == 32'h0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 4'h0) |-> !irq);

endmodule

bind mbox_host_link mbox_host_link_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_full(tx_full),
  .rx_valid(rx_valid), .rx_full(rx_full), .rx_drop(rx_drop), .rx_pop(rx_pop),
  .ovf_flag(ovf_flag), .ovf_clr(ovf_clr), .rd_empty_hit(rd_empty_hit),
  .reg_rdata(reg_rdata), .mask_q(mask_q), .irq(irq)
);

// File: tb/test_mbox_host_link.sv
`timescale 1ns/1ps
module test_mbox_host_link;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        irq;

  int total = 0;
  int bad = 0;
  int tx_got = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #10 clk = ~clk;

  mbox_host_link #(.DEPTH(DEPTH), .ADDR_W(4)) i_mbox_host_link (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic access(input bit wr, input bit rd, input logic [3:0] a,
                        input logic [31:0] wd, output logic [31:0] rv);
    @(posedge clk); #1;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    rv = reg_rdata;
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] wd);
    logic [31:0] rv;
    access(1'b1, 1'b0, a, wd, rv);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] rv);
    access(1'b0, 1'b1, a, '0, rv);
  endtask

  // driver: host byte into the transmit queue, model queues it if room
  task automatic send_byte(input logic [7:0] b);
    if (tx_q.size() < DEPTH) tx_q.push_back(b);
    wr_reg(4'h4, {16'hA5A5, b, 8'h5A});
  endtask

  // driver: controller byte into the receive queue
  task automatic dev_byte(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = b;
    if (rx_q.size() < DEPTH) rx_q.push_back(b);
    @(posedge clk); #1;
    rx_valid = 0; rx_data = '0;
  endtask

  // monitor: host read of the data window versus receive model
  task automatic take_byte(input string tag);
    logic [31:0] rv;
    logic [31:0] exp;
    exp = (rx_q.size() == 0) ? 32'h0 : {16'h0, rx_q.pop_front(), 8'h0};
    rd_reg(4'h4, rv);
    chk(rv == exp, tag, rv, exp);
  endtask

  task automatic stat_is(input logic [31:0] exp, input string tag);
    logic [31:0] rv;
    rd_reg(4'h8, rv);
    chk(rv == exp, tag, rv, exp);
  endtask

  // monitor: transmit stream versus scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      logic [7:0] e;
      e = (tx_q.size() == 0) ? 8'hxx : tx_q.pop_front();
      tx_got++;
      chk(tx_data === e, "R3 transmit byte order", {24'h0, tx_data}, {24'h0, e});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // reset state
    @(negedge clk);
    chk(irq == 0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    chk(tx_valid == 0, "R1 tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    chk(rx_ready == 1, "R5 rx_ready high", {31'h0, rx_ready}, 32'h1);
    stat_is(32'h3, "R1 R9 status after reset");
    rd_reg(4'h0, rv);
    chk(rv == 32'h3, "R1 intr after reset", rv, 32'h3);

    // enables: request bits read-only, mask writable
    wr_reg(4'h0, 32'hFFFF_FFFF);
    rd_reg(4'h0, rv);
    chk(rv == 32'hF3, "R9 R10 intr readback", rv, 32'hF3);
    @(negedge clk);
    chk(irq == 1, "R10 irq tx-empty enabled", {31'h0, irq}, 32'h1);
    wr_reg(4'h0, 32'h40);
    @(negedge clk);
    chk(irq == 0, "R10 irq rx-ne enabled, queue empty", {31'h0, irq}, 32'h0);

    // unused offset
    rd_reg(4'hC, rv);
    chk(rv == 32'h0, "R2 offset 0xC reads zero", rv, 32'h0);
    wr_reg(4'hC, 32'hFFFF_FFFF);
    rd_reg(4'h0, rv);
    chk(rv == 32'h43, "R2 write to 0xC ignored", rv, 32'h43);

    // fill transmit queue with stalled consumer
    for (int i = 0; i < DEPTH - 1; i++) send_byte(8'h10 + 8'(i));
    stat_is(32'h2, "R9 R11 tx seven entries");
    send_byte(8'h17);
    stat_is(32'h0, "R11 tx full clears not-full");
    send_byte(8'h99);
    stat_is(32'h0, "R4 write while full ignored");
    tx_ready = 1;
    for (int i = 0; i < 40 && tx_got < DEPTH; i++) @(posedge clk);
    #1 tx_ready = 0;
    chk(tx_got == DEPTH, "R4 exactly DEPTH bytes sent", tx_got, DEPTH);
    stat_is(32'h3, "R3 R11 tx drained");

    // receive path
    dev_byte(8'hC1);
    dev_byte(8'hC2);
    dev_byte(8'hC3);
    stat_is(32'h7, "R9 rx not empty");
    @(negedge clk);
    chk(irq == 1, "R10 irq rx-ne", {31'h0, irq}, 32'h1);
    take_byte("R5 rx byte 1");
    take_byte("R5 rx byte 2");
    take_byte("R5 rx byte 3");
    take_byte("R6 empty read is zero");
    stat_is(32'h3, "R6 rx empty after reads");
    dev_byte(8'h5E);
    take_byte("R6 pointers kept after empty read");

    // overflow
    wr_reg(4'h0, 32'h80);
    for (int i = 0; i < DEPTH + 1; i++) dev_byte(8'hE0 + 8'(i));
    stat_is(32'hF, "R7 overflow set");
    @(negedge clk);
    chk(irq == 1, "R7 R10 irq on overflow", {31'h0, irq}, 32'h1);
    wr_reg(4'h8, 32'h0);
    stat_is(32'hF, "R8 write zero keeps latch");
    wr_reg(4'h8, 32'h7);
    stat_is(32'hF, "R8 low status ones ignored");
    wr_reg(4'h8, 32'h8);
    stat_is(32'h7, "R8 overflow cleared");
    @(negedge clk);
    chk(irq == 0, "R8 irq drops after clear", {31'h0, irq}, 32'h0);
    for (int i = 0; i < DEPTH; i++) take_byte("R7 kept bytes intact");
    take_byte("R7 dropped byte absent");

    finish_up();
  end

endmodule